// File: doc/BRIEF.md
# Descriptor-driven DMA channel

This block is one channel of a DMA engine that takes its entire job from a transfer descriptor held in memory. Software writes the descriptor address into the channel and sets the run bit. The channel then reads eight 32-bit words from that address and keeps them in registers that software can read back. The descriptor gives the transfer info, the source, the destination, the byte count, a stride, the address of the next descriptor and two spare words. The channel then copies the data one 32-bit word per beat. Each beat is a read from the source followed by a write to the destination.

Either side can keep its address fixed or advance it by four after each beat. Either side can also be paced by one of the peripheral data-request inputs, chosen by a select field in the transfer info. When the byte count reaches zero, a non-zero next-descriptor address makes the channel fetch that descriptor and carry on. A zero next-descriptor address ends the job. The channel then sets its end flag, and it also sets its interrupt flag when the descriptor asked for one.

The channel also has a self-clearing reset command, write-one-to-clear flags and an error flag. A memory error response sets the error flag, and software clears it through the debug register.

The controller is a six-state machine:
- IDLE waits for a start.
- RST holds a reset for a fixed number of cycles.
- FETCH reads the eight descriptor words.
- RD reads one source word.
- WR writes that word.
- CHAIN decides between following the link and finishing.

Its transitions are:
- IDLE→FETCH on a start.
- FETCH→RD, or FETCH→CHAIN for a zero count, after word 7.
- RD→WR after the read completes.
- WR→RD while bytes remain, and WR→CHAIN on the last beat.
- CHAIN→FETCH on a non-zero link, and CHAIN→IDLE on a zero link.
- FETCH, RD or WR →IDLE on an error response.
- Any state →RST on a reset command.
- RST→IDLE when its count expires.

Top module: `cbdma_channel`

## Requirements
- R1: After rst_n is released, every register reads 0, irq is low and mem_req is low.
- R2: Writing a control/status (offset 0x00) word with bit 0 set, while idle and with a non-zero descriptor address, reads the eight words at that address in ascending order. The first six are loaded into read-only copies: 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C next address. A start with a zero descriptor address is ignored.
- R3: The descriptor address register at 0x04 is writable only while idle and always reads with bits 4:0 zero.
- R4: Each beat reads the word at the source address and then writes it to the destination address. The source advances by 4 when info bit 8 is set, and the destination advances by 4 when info bit 4 is set. The length copy drops by 4 per beat, and the data phase ends when it reaches 0. A memory request holds its address until mem_ready.
- R5: Info bit 10 paces the source and info bit 6 paces the destination, using dreq[info[20:16]]. A paced side issues no new request while that input is low, and meanwhile control/status bit 5 reads 1. Control/status bit 3 shows the selected input's level.
- R6: After the data phase, a non-zero next address is copied into 0x04 and fetched. A zero next address clears bit 0 and sets end (bit 1), and it sets interrupt (bit 2) only if info bit 0 is set. irq follows bit 2.
- R7: Writing 1 to control/status bit 1 or bit 2 clears that flag, and writing 0 to them leaves them unchanged.
- R8: An error response (mem_err with mem_ready) sets control/status bit 8, clears bit 0 and stops all requests, and end is not set. Debug register 0x20 reads the error in bit 0, and writing 7 to its bits 2:0 clears it.
- R9: Writing 1 to control/status bit 31 stops the channel at once. Bit 31 then reads 1 for RST_CYCLES cycles and clears by itself, and every register is left at 0.
- R10: Control/status bit 0 reads 1 from the cycle after a start until end, error or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory transaction complete |
| mem_err | input | 1 | Error response, valid with mem_ready |
| dreq | input | N_DREQ | Peripheral data-request inputs |
| irq | output | 1 | Interrupt, equal to the interrupt flag |

## Verification
The main copy path is tried with four patterns, and each separates a different part of the address and pacing logic:
- An incrementing memory-to-memory copy.
- A fixed destination paced by a request line that is held low and then raised. This separates pacing from address stepping.
- A fixed paced source feeding an incrementing destination.
- A two-descriptor chain. This shows that the link reload restarts the fetch from the new address rather than continuing the old count.

An error address, a reset issued while a paced transfer is waiting, and a start with a zero descriptor address cover the ways a job can end without finishing.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RST, S_FETCH, S_RD, S_WR, S_CHAIN
    } state_t;

    // control/status bit positions
    localparam int CS_ACTIVE = 0;
    localparam int CS_END    = 1;
    localparam int CS_INT    = 2;
    localparam int CS_RESET  = 31;

    // transfer-info bit positions
    localparam int TI_INTEN  = 0;
    localparam int TI_DINC   = 4;
    localparam int TI_DPACE  = 6;
    localparam int TI_SINC   = 8;
    localparam int TI_SPACE  = 10;
    localparam int TI_SEL_LO = 16;

    // register byte offsets
    localparam int OFF_CS   = 'h00;
    localparam int OFF_CBA  = 'h04;
    localparam int OFF_TI   = 'h08;
    localparam int OFF_SRC  = 'h0C;
    localparam int OFF_DST  = 'h10;
    localparam int OFF_LEN  = 'h14;
    localparam int OFF_STR  = 'h18;
    localparam int OFF_NXT  = 'h1C;
    localparam int OFF_DBG  = 'h20;

    localparam int DESC_WORDS = 8;
endpackage

// File: rtl/cbdma_dreq_sel.sv
module cbdma_dreq_sel #(
    parameter int N_DREQ = 8,
    parameter int SEL_W  = 5
) (
    input  logic [N_DREQ-1:0] dreq,
    input  logic [SEL_W-1:0]  sel,
    output logic              level
);
    always_comb begin
        level = 1'b0;
        for (int i = 0; i < N_DREQ; i++) begin
            if (sel == SEL_W'(i)) level = dreq[i];
        end
    end
endmodule

// File: rtl/cbdma_addr_step.sv
module cbdma_addr_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] addr,
    input  logic          inc,
    output logic [AW-1:0] nxt
);
    assign nxt = inc ? addr + AW'(STEP) : addr;
endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter int N_DREQ     = 8,
    parameter int RST_CYCLES = 4,
    parameter int REG_AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [N_DREQ-1:0] dreq,
    output logic              irq
);
    localparam int SEL_W = 5;
    localparam int RCW   = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam int FIW   = $clog2(DESC_WORDS);

    state_t         state_q, state_d;
    logic [RCW-1:0] rcnt_q;
    logic [FIW-1:0] fidx_q;
    logic [31:0]    cba_q, ti_q, src_q, dst_q, len_q, str_q, nxt_q, data_q;
    logic           end_q, int_q, err_q, busy_q;
    logic           dreq_lvl, src_wait, dst_wait, waiting, cs_active;
    logic [31:0]    src_nx, dst_nx;
    logic           wr_cs, rst_cmd, beat_done, bus_err;
    logic           unused_bits;

    assign unused_bits = ^reg_wdata[4:3];

    cbdma_dreq_sel #(.N_DREQ(N_DREQ), .SEL_W(SEL_W)) u_sel (
        .dreq(dreq), .sel(ti_q[TI_SEL_LO +: SEL_W]), .level(dreq_lvl));
    cbdma_addr_step #(.AW(32), .STEP(4)) u_src_step (
        .addr(src_q), .inc(ti_q[TI_SINC]), .nxt(src_nx));
    cbdma_addr_step #(.AW(32), .STEP(4)) u_dst_step (
        .addr(dst_q), .inc(ti_q[TI_DINC]), .nxt(dst_nx));

    assign wr_cs     = reg_we && (reg_addr == REG_AW'(OFF_CS));
    assign rst_cmd   = wr_cs && reg_wdata[CS_RESET];
    assign beat_done = mem_req && mem_ready;
    assign bus_err   = beat_done && mem_err;
    assign src_wait  = ti_q[TI_SPACE] && !dreq_lvl;
    assign dst_wait  = ti_q[TI_DPACE] && !dreq_lvl;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rst_cmd) begin
            state_d = S_RST;
        end else begin
            unique case (state_q)
                S_IDLE:  if (wr_cs && reg_wdata[CS_ACTIVE] && cba_q != 32'd0) state_d = S_FETCH;
                S_RST:   if (rcnt_q == '0) state_d = S_IDLE;
                S_FETCH: if (bus_err) state_d = S_IDLE;
                         else if (beat_done && fidx_q == FIW'(DESC_WORDS - 1))
                             state_d = (len_q == 32'd0) ? S_CHAIN : S_RD;
                S_RD:    if (bus_err) state_d = S_IDLE;
                         else if (beat_done) state_d = S_WR;
                S_WR:    if (bus_err) state_d = S_IDLE;
                         else if (beat_done) state_d = (len_q <= 32'd4) ? S_CHAIN : S_RD;
                S_CHAIN: state_d = (nxt_q != 32'd0) ? S_FETCH : S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == S_RST && state_q != S_RST) rcnt_q <= RCW'(RST_CYCLES - 1);
            else if (state_q == S_RST && rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
        end
    end

    // datapath and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cba_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
            str_q <= '0; nxt_q <= '0; data_q <= '0; fidx_q <= '0;
            end_q <= 1'b0; int_q <= 1'b0; err_q <= 1'b0; busy_q <= 1'b0;
        end else if (state_d == S_RST) begin
            cba_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
            str_q <= '0; nxt_q <= '0; data_q <= '0; fidx_q <= '0;
            end_q <= 1'b0; int_q <= 1'b0; err_q <= 1'b0; busy_q <= 1'b0;
        end else begin
            busy_q <= mem_req && !mem_ready;
            if (wr_cs && reg_wdata[CS_END]) end_q <= 1'b0;
            if (wr_cs && reg_wdata[CS_INT]) int_q <= 1'b0;
            if (reg_we && reg_addr == REG_AW'(OFF_CBA) && state_q == S_IDLE)
                cba_q <= {reg_wdata[31:5], 5'd0};
            if (reg_we && reg_addr == REG_AW'(OFF_DBG) && reg_wdata[2:0] == 3'b111)
                err_q <= 1'b0;
            if (state_q == S_IDLE && state_d == S_FETCH) fidx_q <= '0;
            unique case (state_q)
                S_FETCH: if (beat_done && !mem_err) begin
                    case (fidx_q)
                        FIW'(0): ti_q  <= mem_rdata;
                        FIW'(1): src_q <= mem_rdata;
                        FIW'(2): dst_q <= mem_rdata;
                        FIW'(3): len_q <= mem_rdata;
                        FIW'(4): str_q <= mem_rdata;
                        FIW'(5): nxt_q <= mem_rdata;
                        default: ;
                    endcase
                    fidx_q <= fidx_q + 1'b1;
                end
                S_RD: if (beat_done && !mem_err) data_q <= mem_rdata;
                S_WR: if (beat_done && !mem_err) begin
                    src_q <= src_nx;
                    dst_q <= dst_nx;
                    len_q <= len_q - 32'd4;
                end
                S_CHAIN: if (nxt_q != 32'd0) begin
                    cba_q  <= nxt_q;
                    fidx_q <= '0;
                end else begin
                    end_q <= 1'b1;
                    if (ti_q[TI_INTEN]) int_q <= 1'b1;
                end
                default: ;
            endcase
            if (bus_err) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cba_q + {{(30-FIW){1'b0}}, fidx_q, 2'b00};
            end
            S_RD: begin
                mem_req  = busy_q || !src_wait;
                mem_addr = src_q;
            end
            S_WR: begin
                mem_req   = busy_q || !dst_wait;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = data_q;
            end
            default: ;
        endcase
    end

    assign cs_active = (state_q == S_FETCH) || (state_q == S_RD) ||
                       (state_q == S_WR) || (state_q == S_CHAIN);
    assign waiting   = !busy_q && ((state_q == S_RD && src_wait) ||
                                   (state_q == S_WR && dst_wait));
    assign irq = int_q;

    always_comb begin
        case (reg_addr)
            REG_AW'(OFF_CS):  reg_rdata = {state_q == S_RST, 22'd0, err_q, 2'b00, waiting,
                                           1'b0, dreq_lvl, int_q, end_q, cs_active};
            REG_AW'(OFF_CBA): reg_rdata = cba_q;
            REG_AW'(OFF_TI):  reg_rdata = ti_q;
            REG_AW'(OFF_SRC): reg_rdata = src_q;
            REG_AW'(OFF_DST): reg_rdata = dst_q;
            REG_AW'(OFF_LEN): reg_rdata = len_q;
            REG_AW'(OFF_STR): reg_rdata = str_q;
            REG_AW'(OFF_NXT): reg_rdata = nxt_q;
            REG_AW'(OFF_DBG): reg_rdata = {31'd0, err_q};
            default:          reg_rdata = 32'd0;
        endcase
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !rst_cmd) |=> (mem_req && $stable(mem_addr)));
    // R5
    pace_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD && !busy_q && ti_q[TI_SPACE] && !dreq_lvl) |-> !mem_req);
    // R5
    pace_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR && !busy_q && ti_q[TI_DPACE] && !dreq_lvl) |-> !mem_req);
    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !rst_cmd) |=> (err_q && !cs_active && !mem_req && !$rose(end_q)));
    // R6
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_q) |-> (!cs_active && !mem_req));
    // R9
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RST) |-> (!mem_req && !irq && !end_q));
endmodule

// File: tb/cbdma_channel_tb.sv
module cbdma_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mrdata = '0;
    logic        mready = 1'b0, merr = 1'b0;
    logic [7:0]  dreq = 8'h00;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] mem [0:255];
    logic [63:0] expq [$];

    always #10 clk = ~clk;

    cbdma_channel dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mrdata), .mem_ready(mready), .mem_err(merr),
        .dreq(dreq), .irq(irq));

    // behavioural memory: one-cycle ready, bit 31 of the address answers with an error
    always @(posedge clk) begin
        if (!rst_n) begin
            mready <= 1'b0;
            merr   <= 1'b0;
        end else begin
            mready <= mem_req && !mready;
            if (mem_req && !mready) begin
                mrdata <= mem[mem_addr[9:2]];
                merr   <= mem_addr[31];
            end
            if (mem_req && mready && mem_we && !mem_addr[31])
                mem[mem_addr[9:2]] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference stream of writes, compared on every completing write
    always @(negedge clk) begin
        if (rst_n && mem_req && mready && mem_we) begin
            if (expq.size() == 0) check(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, 64'd0);
            else begin
                logic [63:0] e;
                e = expq.pop_front();
                check({mem_addr, mem_wdata} == e, "R4 write stream", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            finish_run();
        end
    end

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            reg_read(6'h00, v);
            if (!v[0]) return;
        end
        check(1'b0, "R10 channel never went idle", 64'(v), 64'd0);
    endtask

    task automatic put_desc(input int base, input logic [31:0] ti, src, dst, len, nxt);
        mem[base/4]     = ti;
        mem[base/4 + 1] = src;
        mem[base/4 + 2] = dst;
        mem[base/4 + 3] = len;
        mem[base/4 + 4] = 32'd0;
        mem[base/4 + 5] = nxt;
        mem[base/4 + 6] = 32'hDEAD_0006;
        mem[base/4 + 7] = 32'hDEAD_0007;
    endtask

    task automatic expect_write(input logic [31:0] a, input logic [31:0] d);
        expq.push_back({a, d});
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(6'h00, v); check(v == 32'd0, "R1 control/status", 64'(v), 64'd0);
        reg_read(6'h04, v); check(v == 32'd0, "R1 descriptor address", 64'(v), 64'd0);
        check(irq == 1'b0 && mem_req == 1'b0, "R1 irq/mem_req", {62'd0, irq, mem_req}, 64'd0);

        // R3 alignment of descriptor address
        reg_write(6'h04, 32'h0000_0127);
        reg_read(6'h04, v); check(v == 32'h120, "R3 aligned address", 64'(v), 64'h120);

        // R2 start with zero descriptor address is ignored
        reg_write(6'h04, 32'd0);
        reg_write(6'h00, 32'd1);
        reg_read(6'h00, v); check(v == 32'd0, "R2 zero-address start ignored", 64'(v), 64'd0);

        // R4 incrementing memory-to-memory copy with interrupt
        put_desc(32'h100, 32'h111, 32'h200, 32'h300, 32'd16, 32'd0);
        for (int i = 0; i < 4; i++) expect_write(32'h300 + 32'(4*i), mem[(32'h200 >> 2) + i]);
        reg_write(6'h04, 32'h100);
        reg_write(6'h00, 32'd1);
        reg_read(6'h00, v); check(v[0] == 1'b1, "R10 active after start", 64'(v[0]), 64'd1);
        wait_idle();
        reg_read(6'h00, v); check(v == 32'h6, "R6 end+int after copy", 64'(v), 64'h6);
        check(irq == 1'b1, "R6 irq follows interrupt flag", 64'(irq), 64'd1);
        reg_read(6'h08, v); check(v == 32'h111, "R2 info copy", 64'(v), 64'h111);
        reg_read(6'h0C, v); check(v == 32'h210, "R4 source advanced", 64'(v), 64'h210);
        reg_read(6'h14, v); check(v == 32'd0, "R4 length drained", 64'(v), 64'd0);
        check(mem[32'h30C >> 2] == mem[32'h20C >> 2], "R4 last word copied",
              64'(mem[32'h30C >> 2]), 64'(mem[32'h20C >> 2]));

        // R7 write-one-to-clear
        reg_write(6'h00, 32'h4);
        reg_read(6'h00, v); check(v == 32'h2, "R7 clear interrupt only", 64'(v), 64'h2);
        check(irq == 1'b0, "R7 irq dropped", 64'(irq), 64'd0);
        reg_write(6'h00, 32'h0);
        reg_read(6'h00, v); check(v == 32'h2, "R7 writing zero keeps end", 64'(v), 64'h2);
        reg_write(6'h00, 32'h2);
        reg_read(6'h00, v); check(v == 32'h0, "R7 clear end", 64'(v), 64'h0);

        // R5 destination paced by dreq[2], fixed destination, no interrupt
        put_desc(32'h140, 32'h0002_0140, 32'h240, 32'h3F0, 32'd12, 32'd0);
        for (int i = 0; i < 3; i++) expect_write(32'h3F0, mem[(32'h240 >> 2) + i]);
        reg_write(6'h04, 32'h140);
        reg_write(6'h00, 32'd1);
        repeat (30) @(negedge clk);
        reg_read(6'h00, v); check(v == 32'h21, "R5 waiting on low dreq", 64'(v), 64'h21);
        check(expq.size() == 3, "R5 no write while dreq low", 64'(expq.size()), 64'd3);
        dreq[2] = 1'b1;
        wait_idle();
        dreq[2] = 1'b0;
        reg_read(6'h00, v); check(v == 32'h2, "R6 end without interrupt", 64'(v), 64'h2);
        check(irq == 1'b0, "R6 no irq when disabled", 64'(irq), 64'd0);
        check(expq.size() == 0, "R5 paced writes all seen", 64'(expq.size()), 64'd0);
        reg_write(6'h00, 32'h2);

        // R5 fixed source paced by dreq[3] into an incrementing destination
        put_desc(32'h160, 32'h0003_0410, 32'h3F0, 32'h380, 32'd8, 32'd0);
        expect_write(32'h380, mem[32'h3F0 >> 2]);
        expect_write(32'h384, mem[32'h3F0 >> 2]);
        dreq[3] = 1'b1;
        reg_write(6'h04, 32'h160);
        reg_write(6'h00, 32'd1);
        wait_idle();
        dreq[3] = 1'b0;
        reg_read(6'h10, v); check(v == 32'h388, "R4 destination advanced", 64'(v), 64'h388);
        reg_read(6'h0C, v); check(v == 32'h3F0, "R4 fixed source held", 64'(v), 64'h3F0);
        reg_write(6'h00, 32'h2);

        // R6 chain of two descriptors
        put_desc(32'h180, 32'h110, 32'h200, 32'h340, 32'd8, 32'h1A0);
        put_desc(32'h1A0, 32'h111, 32'h208, 32'h348, 32'd8, 32'd0);
        for (int i = 0; i < 4; i++) expect_write(32'h340 + 32'(4*i), mem[(32'h200 >> 2) + i]);
        reg_write(6'h04, 32'h180);
        reg_write(6'h00, 32'd1);
        wait_idle();
        reg_read(6'h00, v); check(v == 32'h6, "R6 chain ends with end+int", 64'(v), 64'h6);
        reg_read(6'h04, v); check(v == 32'h1A0, "R6 link copied to address", 64'(v), 64'h1A0);
        reg_read(6'h1C, v); check(v == 32'd0, "R2 next copy of last link", 64'(v), 64'd0);
        check(expq.size() == 0, "R6 both descriptors copied", 64'(expq.size()), 64'd0);
        reg_write(6'h00, 32'h6);

        // R8 error response
        put_desc(32'h1C0, 32'h110, 32'h8000_0000, 32'h360, 32'd4, 32'd0);
        reg_write(6'h04, 32'h1C0);
        reg_write(6'h00, 32'd1);
        wait_idle();
        reg_read(6'h00, v); check(v == 32'h100, "R8 error set, no end", 64'(v), 64'h100);
        reg_read(6'h20, v); check(v == 32'h1, "R8 debug shows error", 64'(v), 64'h1);
        reg_write(6'h20, 32'h7);
        reg_read(6'h00, v); check(v == 32'h0, "R8 error cleared", 64'(v), 64'h0);

        // R9 reset while a paced transfer waits
        put_desc(32'h1E0, 32'h0004_0140, 32'h200, 32'h3F8, 32'd8, 32'd0);
        reg_write(6'h04, 32'h1E0);
        reg_write(6'h00, 32'd1);
        repeat (30) @(negedge clk);
        reg_read(6'h00, v); check(v == 32'h21, "R5 waiting before reset", 64'(v), 64'h21);
        reg_write(6'h00, 32'h8000_0000);
        reg_read(6'h00, v); check(v == 32'h8000_0000, "R9 reset bit reads 1", 64'(v), 64'h8000_0000);
        repeat (5) @(negedge clk);
        reg_read(6'h00, v); check(v == 32'h0, "R9 reset bit self-clears", 64'(v), 64'h0);
        reg_read(6'h04, v); check(v == 32'h0, "R9 address cleared", 64'(v), 64'h0);
        reg_read(6'h08, v); check(v == 32'h0, "R9 info cleared", 64'(v), 64'h0);
        check(mem_req == 1'b0, "R9 no request after reset", 64'(mem_req), 64'd0);

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R4 no pending expected writes", 64'(expq.size()), 64'd0);
        finish_run();
    end
endmodule